// File: doc/BRIEF.md
# Multi-segment FMCW ramp sequencer

This block turns a small table of linear segments into a piecewise-linear offset that a fractional-N synthesizer adds to its feedback numerator. On each phase-detector tick, the active segment adds its signed step to a 33-bit accumulator. The segment counts down its programmed length, which is doubled when its slow bit is set. When the length runs out, the block either moves straight to the segment named in the table entry, or first waits for a rising edge on one of three trigger inputs.

The accumulator is clamped to an upper and a lower limit. Two comparators report when the waveform has crossed a threshold in its current direction of travel. A start pulse always begins the waveform at segment 0 with a zero offset. The chain runs until enable drops, or until a nonzero repeat count of passes through segment 0 has been used up. At that point the offset freezes and done rises.

The table is loaded through a single-entry write port. The limits, thresholds and repeat count are static configuration inputs.

Top module: `chirp_ramp_seq`

## Requirements
- R1: After reset, offset, seg_idx, seg_flags, fastlock, cmp0, cmp1 and done are all zero.
- R2: A start pulse with enable high sets offset to 0, seg_idx to 0 and done to 0 at the next clock edge. A start pulse while enable is low is ignored, and nothing runs afterwards.
- R3: While a segment is running, each clock with tick high adds the segment's 30-bit two's-complement step, sign-extended, to the 33-bit offset. The new offset is visible after that same clock edge.
- R4: A segment lasts max(len,1) ticks, or twice that many when its slow bit is set. After its last tick, a segment with wait mode 0 hands over to the segment in its 3-bit next field.
- R5: Wait mode encoding: 0 means advance on completion, 1 means wait for trigger A, 2 for trigger B, 3 for trigger C. While a segment is waiting, ticks leave offset unchanged. The clock that samples the selected trigger high, after it was low at the previous clock, moves seg_idx to the next segment.
- R6: Every update of offset is clamped, as a signed value, to the range lim_lo to lim_hi.
- R7: The direction is rising after start and after any applied step of zero or more, and falling after a negative step. While rising, cmpN is 1 when offset > thrN; while falling, cmpN is 1 when offset < thrN (all compared as signed values).
- R8: While the sequencer runs, seg_flags and fastlock show the 2-bit flag field and the fastlock bit of the active segment. Otherwise both are 0.
- R9: With rpt_cnt equal to 0 the chain runs without end. With rpt_cnt equal to N > 0, the N-th move into segment 0 instead stops the sequencer. It raises done, keeps seg_idx, and holds offset until the next start.
- R10: Dropping enable stops the sequencer. offset and seg_idx hold, and raising enable again does not resume without a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Phase-detector cycle strobe |
| start | input | 1 | Begin the waveform at segment 0 |
| enable | input | 1 | Run enable |
| trig_a | input | 1 | External trigger A |
| trig_b | input | 1 | External trigger B |
| trig_c | input | 1 | External trigger C |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Table entry written |
| cfg_inc | input | 30 | Step per tick, two's complement |
| cfg_len | input | 16 | Segment length in ticks |
| cfg_dbl | input | 1 | Slow bit: each length count lasts two ticks |
| cfg_next | input | 3 | Index of the following segment |
| cfg_mode | input | 2 | Wait mode (R5 encoding) |
| cfg_fl | input | 1 | Fastlock request while active |
| cfg_flag | input | 2 | Flag field while active |
| lim_hi | input | 33 | Upper clamp, signed |
| lim_lo | input | 33 | Lower clamp, signed |
| thr0 | input | 33 | Comparator 0 threshold, signed |
| thr1 | input | 33 | Comparator 1 threshold, signed |
| rpt_cnt | input | 13 | Pattern repeat count, 0 means endless |
| offset | output | 33 | Signed numerator offset |
| seg_idx | output | 3 | Active segment |
| seg_flags | output | 2 | Active segment flags |
| fastlock | output | 1 | Active segment fastlock request |
| cmp0 | output | 1 | Comparator 0 flag |
| cmp1 | output | 1 | Comparator 1 flag |
| done | output | 1 | Repeat count used up |

## Verification
Every register on the path from a sampled input to a port is one flop deep. A tick, a trigger edge, a start or an enable change therefore shows up in offset, seg_idx, done, flags and fastlock right after the clock edge that samples it. The comparator flags are combinational on the offset and direction registers, so they share that same cycle. The bench drives inputs 5 ns after a rising edge and steps its reference model at the next rising edge. It compares every output 5 ns after that edge, so each result is checked in exactly the cycle it becomes due. Directed sequences pin down hand-computed values at segment ends, at clamp boundaries and at the repeat stop, and random sequences cover the rest.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
   // how a segment hands over once its length is used up
   typedef enum logic [1:0] {
      ADV_ON_END = 2'd0,
      WAIT_TRG_A = 2'd1,
      WAIT_TRG_B = 2'd2,
      WAIT_TRG_C = 2'd3
   } adv_mode_e;

   localparam int unsigned NUM_TRG = 3;
   localparam int unsigned FLAG_W  = 2;
endpackage

// File: rtl/chirp_seg_table.sv
module chirp_seg_table
   import chirp_pkg::*;
#(
   parameter int unsigned NSEG  = 8,
   parameter int unsigned INC_W = 30,
   parameter int unsigned LEN_W = 16,
   localparam int unsigned IDX_W = $clog2(NSEG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [INC_W-1:0]   wr_inc,
   input  logic [LEN_W-1:0]   wr_len,
   input  logic               wr_dbl,
   input  logic [IDX_W-1:0]   wr_next,
   input  logic [1:0]         wr_mode,
   input  logic               wr_fl,
   input  logic [FLAG_W-1:0]  wr_flag,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [INC_W-1:0]   rd_inc,
   output logic [LEN_W-1:0]   rd_len,
   output logic               rd_dbl,
   output logic [IDX_W-1:0]   rd_next,
   output adv_mode_e          rd_mode,
   output logic               rd_fl,
   output logic [FLAG_W-1:0]  rd_flag
);
   localparam int unsigned ENT_W = INC_W + LEN_W + 1 + IDX_W + 2 + 1 + FLAG_W;

   logic [ENT_W-1:0] ent [NSEG];
   logic [ENT_W-1:0] wr_word;
   logic [ENT_W-1:0] rd_word;

   assign wr_word = {wr_inc, wr_len, wr_dbl, wr_next, wr_mode, wr_fl, wr_flag};

   for (genvar i = 0; i < NSEG; i++) begin : g_ent
      logic [ENT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            q <= wr_word;
      end
      assign ent[i] = q;
   end

   assign rd_word = ent[rd_idx];

   logic [1:0] mode_bits;
   assign {rd_inc, rd_len, rd_dbl, rd_next, mode_bits, rd_fl, rd_flag} = rd_word;
   assign rd_mode = adv_mode_e'(mode_bits);

   initial begin
      assert (NSEG >= 2 && (1 << IDX_W) == NSEG)
         else $error("chirp_seg_table: NSEG must be a power of two >= 2");
   end
endmodule

// File: rtl/chirp_seg_timer.sv
module chirp_seg_timer #(
   parameter int unsigned LEN_W = 16,
   localparam int unsigned CNT_W = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [LEN_W-1:0] len,
   input  logic             dbl,
   output logic             last
);
   logic [CNT_W-1:0] cnt;
   logic [LEN_W-1:0] eff_len;
   logic [CNT_W-1:0] total;

   // a zero length still runs for one count
   assign eff_len = (len == '0) ? LEN_W'(1) : len;
   assign total   = dbl ? {eff_len, 1'b0} : {1'b0, eff_len};
   assign last    = (cnt == total - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (adv)
         cnt <= last ? '0 : cnt + CNT_W'(1);
   end

   // a doubled segment always ends on an odd count
   p_dbl_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last && dbl && !clr) |-> cnt[0]);

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |-> (cnt < total));
endmodule

// File: rtl/chirp_clamp_add.sv
module chirp_clamp_add #(
   parameter int unsigned ACC_W = 33,
   parameter int unsigned INC_W = 30
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [INC_W-1:0] inc,
   input  logic [ACC_W-1:0] hi,
   input  logic [ACC_W-1:0] lo,
   output logic [ACC_W-1:0] sum_q
);
   localparam int unsigned SW = ACC_W + 1;

   logic signed [SW-1:0] sum_w;
   logic signed [SW-1:0] hi_w;
   logic signed [SW-1:0] lo_w;

   assign sum_w = $signed({acc[ACC_W-1], acc})
                + $signed({{(SW-INC_W){inc[INC_W-1]}}, inc});
   assign hi_w  = $signed({hi[ACC_W-1], hi});
   assign lo_w  = $signed({lo[ACC_W-1], lo});

   always_comb begin
      if (sum_w > hi_w)
         sum_q = hi;
      else if (sum_w < lo_w)
         sum_q = lo;
      else
         sum_q = sum_w[ACC_W-1:0];
   end

   initial begin
      assert (INC_W < ACC_W)
         else $error("chirp_clamp_add: step must be narrower than accumulator");
   end
endmodule

// File: rtl/chirp_cmp.sv
module chirp_cmp #(
   parameter int unsigned ACC_W = 33
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] thr,
   input  logic             rising,
   output logic             hit
);
   assign hit = rising ? ($signed(acc) > $signed(thr))
                       : ($signed(acc) < $signed(thr));
endmodule

// File: rtl/chirp_ramp_seq.sv
module chirp_ramp_seq
   import chirp_pkg::*;
#(
   parameter int unsigned NSEG  = 8,
   parameter int unsigned INC_W = 30,
   parameter int unsigned LEN_W = 16,
   parameter int unsigned ACC_W = 33,
   parameter int unsigned RPT_W = 13,
   localparam int unsigned IDX_W = $clog2(NSEG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               start,
   input  logic               enable,
   input  logic               trig_a,
   input  logic               trig_b,
   input  logic               trig_c,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [INC_W-1:0]   cfg_inc,
   input  logic [LEN_W-1:0]   cfg_len,
   input  logic               cfg_dbl,
   input  logic [IDX_W-1:0]   cfg_next,
   input  logic [1:0]         cfg_mode,
   input  logic               cfg_fl,
   input  logic [1:0]         cfg_flag,
   input  logic [ACC_W-1:0]   lim_hi,
   input  logic [ACC_W-1:0]   lim_lo,
   input  logic [ACC_W-1:0]   thr0,
   input  logic [ACC_W-1:0]   thr1,
   input  logic [RPT_W-1:0]   rpt_cnt,
   output logic [ACC_W-1:0]   offset,
   output logic [IDX_W-1:0]   seg_idx,
   output logic [1:0]         seg_flags,
   output logic               fastlock,
   output logic               cmp0,
   output logic               cmp1,
   output logic               done
);
   localparam int unsigned NCMP = 2;

   // ---------------- state ----------------
   logic               run_q;
   logic               wait_q;
   logic               done_q;
   logic               dir_up_q;
   logic [ACC_W-1:0]   acc_q;
   logic [IDX_W-1:0]   seg_q;
   logic [RPT_W-1:0]   rpt_q;
   logic [NUM_TRG-1:0] trg_q;

   // ---------------- active entry ----------------
   logic [INC_W-1:0]   cur_inc;
   logic [LEN_W-1:0]   cur_len;
   logic               cur_dbl;
   logic [IDX_W-1:0]   cur_next;
   adv_mode_e          cur_mode;
   logic               cur_fl;
   logic [1:0]         cur_flag;

   chirp_seg_table #(.NSEG(NSEG), .INC_W(INC_W), .LEN_W(LEN_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_inc  (cfg_inc),
      .wr_len  (cfg_len),
      .wr_dbl  (cfg_dbl),
      .wr_next (cfg_next),
      .wr_mode (cfg_mode),
      .wr_fl   (cfg_fl),
      .wr_flag (cfg_flag),
      .rd_idx  (seg_q),
      .rd_inc  (cur_inc),
      .rd_len  (cur_len),
      .rd_dbl  (cur_dbl),
      .rd_next (cur_next),
      .rd_mode (cur_mode),
      .rd_fl   (cur_fl),
      .rd_flag (cur_flag)
   );

   // ---------------- control decode ----------------
   logic               start_go;
   logic               live;
   logic               step;
   logic               seg_last;
   logic               seg_end;
   logic [NUM_TRG-1:0] trg_now;
   logic [NUM_TRG-1:0] trg_rise;
   logic               trg_hit;
   logic               adv;
   logic               wrap;
   logic [ACC_W-1:0]   acc_nxt;

   assign start_go = start & enable;
   assign live     = run_q & enable & ~start_go;
   assign step     = live & ~wait_q & tick;
   assign seg_end  = step & seg_last;
   assign trg_now  = {trig_c, trig_b, trig_a};
   assign trg_rise = trg_now & ~trg_q;

   always_comb begin
      unique case (cur_mode)
         WAIT_TRG_A: trg_hit = trg_rise[0];
         WAIT_TRG_B: trg_hit = trg_rise[1];
         WAIT_TRG_C: trg_hit = trg_rise[2];
         default:    trg_hit = 1'b0;
      endcase
   end

   assign adv  = (seg_end & (cur_mode == ADV_ON_END)) | (live & wait_q & trg_hit);
   assign wrap = (cur_next == '0);

   chirp_seg_timer #(.LEN_W(LEN_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_go),
      .adv   (step),
      .len   (cur_len),
      .dbl   (cur_dbl),
      .last  (seg_last)
   );

   chirp_clamp_add #(.ACC_W(ACC_W), .INC_W(INC_W)) u_add (
      .acc   (acc_q),
      .inc   (cur_inc),
      .hi    (lim_hi),
      .lo    (lim_lo),
      .sum_q (acc_nxt)
   );

   // ---------------- sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trg_q <= '0;
      end else begin
         trg_q <= trg_now;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         wait_q   <= 1'b0;
         done_q   <= 1'b0;
         dir_up_q <= 1'b1;
         acc_q    <= '0;
         seg_q    <= '0;
         rpt_q    <= '0;
      end else if (start_go) begin
         run_q    <= 1'b1;
         wait_q   <= 1'b0;
         done_q   <= 1'b0;
         dir_up_q <= 1'b1;
         acc_q    <= '0;
         seg_q    <= '0;
         rpt_q    <= rpt_cnt;
      end else if (!enable) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         if (step) begin
            acc_q    <= acc_nxt;
            dir_up_q <= ~cur_inc[INC_W-1];
         end
         if (seg_end && (cur_mode != ADV_ON_END))
            wait_q <= 1'b1;
         if (adv) begin
            wait_q <= 1'b0;
            if (wrap && (rpt_q != '0)) begin
               if (rpt_q == RPT_W'(1)) begin
                  done_q <= 1'b1;
                  run_q  <= 1'b0;
               end else begin
                  rpt_q <= rpt_q - RPT_W'(1);
                  seg_q <= cur_next;
               end
            end else begin
               seg_q <= cur_next;
            end
         end
      end
   end

   // ---------------- comparators ----------------
   logic [ACC_W-1:0] thr_v [NCMP];
   logic [NCMP-1:0]  hit_v;

   assign thr_v[0] = thr0;
   assign thr_v[1] = thr1;

   for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      chirp_cmp #(.ACC_W(ACC_W)) u_cmp (
         .acc    (acc_q),
         .thr    (thr_v[k]),
         .rising (dir_up_q),
         .hit    (hit_v[k])
      );
   end

   // ---------------- outputs ----------------
   assign offset    = acc_q;
   assign seg_idx   = seg_q;
   assign seg_flags = run_q ? cur_flag : 2'b00;
   assign fastlock  = run_q & cur_fl;
   assign cmp0      = hit_v[0];
   assign cmp1      = hit_v[1];
   assign done      = done_q;

   // ---------------- assertions ----------------
   initial begin
      assert (RPT_W >= 1 && LEN_W >= 1)
         else $error("chirp_ramp_seq: bad width parameter");
   end

   p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && enable) |=> (seg_idx == '0 && offset == '0 && !done));

   p_clamp_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ($signed(offset) <= $signed($past(lim_hi))));

   p_clamp_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ($signed(offset) >= $signed($past(lim_lo))));

   p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && wait_q && enable && !start) |=> $stable(offset));

   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(offset) && $stable(seg_idx)));

   p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !run_q) |=> ($stable(offset) && $stable(seg_idx)));

   p_idle_outs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (seg_flags == 2'b00 && !fastlock));
endmodule

// File: tb/chirp_ramp_seq_tb.sv
`timescale 1ns/1ps
module chirp_ramp_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        tick = 0, start = 0, enable = 0;
   logic        trig_a = 0, trig_b = 0, trig_c = 0;
   logic        cfg_we = 0;
   logic [2:0]  cfg_idx = 0, cfg_next = 0;
   logic [29:0] cfg_inc = 0;
   logic [15:0] cfg_len = 0;
   logic        cfg_dbl = 0, cfg_fl = 0;
   logic [1:0]  cfg_mode = 0, cfg_flag = 0;
   logic [32:0] lim_hi, lim_lo, thr0, thr1;
   logic [12:0] rpt_cnt = 0;
   logic [32:0] offset;
   logic [2:0]  seg_idx;
   logic [1:0]  seg_flags;
   logic        fastlock, cmp0, cmp1, done;

   chirp_ramp_seq u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .enable(enable),
      .trig_a(trig_a), .trig_b(trig_b), .trig_c(trig_c),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_inc(cfg_inc), .cfg_len(cfg_len),
      .cfg_dbl(cfg_dbl), .cfg_next(cfg_next), .cfg_mode(cfg_mode),
      .cfg_fl(cfg_fl), .cfg_flag(cfg_flag),
      .lim_hi(lim_hi), .lim_lo(lim_lo), .thr0(thr0), .thr1(thr1),
      .rpt_cnt(rpt_cnt),
      .offset(offset), .seg_idx(seg_idx), .seg_flags(seg_flags),
      .fastlock(fastlock), .cmp0(cmp0), .cmp1(cmp1), .done(done)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // limits and thresholds held as signed integers on the bench side
   longint v_hi, v_lo, v_t0, v_t1;
   always_comb begin
      lim_hi = v_hi[32:0];
      lim_lo = v_lo[32:0];
      thr0   = v_t0[32:0];
      thr1   = v_t1[32:0];
   end

   // ---------------- reference model ----------------
   longint t_inc [8];
   int     t_len [8], t_next [8], t_mode [8], t_flag [8];
   bit     t_dbl [8], t_fl [8];
   bit     m_run, m_done, m_wt, m_up;
   int     m_seg, m_cnt, m_rpt;
   longint m_acc;
   bit     pa, pb, pc;

   function automatic longint sx30(input logic [29:0] v);
      return v[29] ? longint'(v) - (longint'(1) << 30) : longint'(v);
   endfunction

   function automatic longint clampv(input longint s);
      if (s > v_hi) return v_hi;
      if (s < v_lo) return v_lo;
      return s;
   endfunction

   function automatic int seg_ticks(input int s);
      int l = (t_len[s] == 0) ? 1 : t_len[s];
      return t_dbl[s] ? 2 * l : l;
   endfunction

   task automatic m_advance();
      int nx = t_next[m_seg];
      m_wt = 0;
      if (nx == 0 && m_rpt != 0) begin
         if (m_rpt == 1) begin m_done = 1; m_run = 0; end
         else begin m_rpt--; m_seg = 0; end
      end else m_seg = nx;
   endtask

   task automatic m_update();
      bit ea = trig_a & ~pa, eb = trig_b & ~pb, ec = trig_c & ~pc;
      if (start && enable) begin
         m_run = 1; m_done = 0; m_seg = 0; m_acc = 0; m_cnt = 0;
         m_wt = 0; m_rpt = int'(rpt_cnt); m_up = 1;
      end else if (!enable) begin
         m_run = 0;
      end else if (m_run) begin
         if (m_wt) begin
            bit hit = (t_mode[m_seg] == 1 && ea) || (t_mode[m_seg] == 2 && eb) ||
                      (t_mode[m_seg] == 3 && ec);
            if (hit) m_advance();
         end else if (tick) begin
            m_acc = clampv(m_acc + t_inc[m_seg]);
            m_up  = (t_inc[m_seg] >= 0);
            if (m_cnt == seg_ticks(m_seg) - 1) begin
               m_cnt = 0;
               if (t_mode[m_seg] == 0) m_advance(); else m_wt = 1;
            end else m_cnt++;
         end
      end
      if (cfg_we) begin
         t_inc[cfg_idx] = sx30(cfg_inc); t_len[cfg_idx] = int'(cfg_len);
         t_dbl[cfg_idx] = cfg_dbl; t_next[cfg_idx] = int'(cfg_next);
         t_mode[cfg_idx] = int'(cfg_mode); t_fl[cfg_idx] = cfg_fl;
         t_flag[cfg_idx] = int'(cfg_flag);
      end
      pa = trig_a; pb = trig_b; pc = trig_c;
   endtask

   // ---------------- checking ----------------
   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic longint off_s();
      return offset[32] ? longint'(offset) - (longint'(1) << 33) : longint'(offset);
   endfunction

   task automatic cmp_all();
      bit e0 = m_up ? (m_acc > v_t0) : (m_acc < v_t0);
      bit e1 = m_up ? (m_acc > v_t1) : (m_acc < v_t1);
      chk("R3", "offset", off_s(), m_acc);
      chk("R4", "seg_idx", seg_idx, m_seg);
      chk("R8", "seg_flags", seg_flags, m_run ? t_flag[m_seg] : 0);
      chk("R8", "fastlock", fastlock, m_run ? t_fl[m_seg] : 0);
      chk("R7", "cmp0", cmp0, e0);
      chk("R7", "cmp1", cmp1, e1);
      chk("R9", "done", done, m_done);
   endtask

   // one clock: DUT and model sample the inputs at the edge, outputs read 5 ns later
   task automatic step();
      @(posedge clk);
      m_update();
      #5;
      cmp_all();
   endtask

   task automatic ticks(input int n);
      tick = 1;
      for (int i = 0; i < n; i++) step();
      tick = 0;
   endtask

   task automatic wr_seg(input int idx, input longint inc, input int len, input bit dbl,
                         input int nx, input int mode, input bit fl, input int flag);
      cfg_we = 1; cfg_idx = 3'(idx); cfg_inc = 30'(inc); cfg_len = 16'(len);
      cfg_dbl = dbl; cfg_next = 3'(nx); cfg_mode = 2'(mode); cfg_fl = fl; cfg_flag = 2'(flag);
      step();
      cfg_we = 0;
   endtask

   task automatic do_start();
      start = 1; step(); start = 0;
   endtask

   task automatic pulse_a();
      trig_a = 1; step(); trig_a = 0; step();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(20ns * 190000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 8; i++) begin
         t_inc[i] = 0; t_len[i] = 0; t_next[i] = 0; t_mode[i] = 0;
         t_flag[i] = 0; t_dbl[i] = 0; t_fl[i] = 0;
      end
      m_run = 0; m_done = 0; m_wt = 0; m_up = 1; m_seg = 0; m_cnt = 0; m_rpt = 0;
      m_acc = 0; pa = 0; pb = 0; pc = 0;
      v_hi = (longint'(1) << 32) - 1; v_lo = -(longint'(1) << 32);
      v_t0 = 0; v_t1 = 0;
      void'($urandom(32'd2718));

      repeat (3) @(posedge clk);
      #5 rst_n = 1;
      #1;
      // R1 reset state
      chk("R1", "offset", off_s(), 0);
      chk("R1", "seg_idx", seg_idx, 0);
      chk("R1", "flags", seg_flags, 0);
      chk("R1", "fastlock", fastlock, 0);
      chk("R1", "cmp", {cmp0, cmp1}, 0);
      chk("R1", "done", done, 0);

      // directed chain: 0 -> 1 (wait A, zero length doubled) -> 2 -> wrap
      wr_seg(0, 100, 3, 0, 1, 0, 0, 1);
      wr_seg(1, -7,  0, 1, 2, 1, 0, 2);
      wr_seg(2, 0,   1, 0, 0, 0, 1, 3);
      rpt_cnt = 13'd2;

      // R2 start ignored while enable low
      do_start();
      enable = 1;
      ticks(3);
      chk("R2", "offset after ignored start", off_s(), 0);
      chk("R2", "seg after ignored start", seg_idx, 0);

      do_start();
      chk("R2", "offset at start", off_s(), 0);
      ticks(3);
      chk("R3", "offset after three steps", off_s(), 300);
      chk("R4", "seg after length 3", seg_idx, 1);
      ticks(2);
      chk("R4", "offset after zero-length doubled", off_s(), 286);
      ticks(4);
      chk("R5", "offset frozen while waiting", off_s(), 286);
      chk("R5", "seg while waiting", seg_idx, 1);
      trig_b = 1; step(); trig_b = 0; step();
      chk("R5", "other trigger ignored", seg_idx, 1);
      trig_a = 1; step();
      chk("R5", "seg after trigger A edge", seg_idx, 2);
      chk("R8", "flags of seg 2", seg_flags, 3);
      chk("R8", "fastlock of seg 2", fastlock, 1);
      trig_a = 0; step();
      ticks(1);
      chk("R9", "wrap into seg 0", seg_idx, 0);
      chk("R9", "not done after first pass", done, 0);
      ticks(5);
      pulse_a();
      ticks(1);
      chk("R9", "done after second pass", done, 1);
      chk("R9", "offset held at stop", off_s(), 572);
      chk("R8", "flags cleared when stopped", seg_flags, 0);
      ticks(3);
      chk("R9", "offset held after done", off_s(), 572);

      // clamp and comparator scenario
      enable = 0; step();
      v_hi = 250; v_lo = -40; v_t0 = 120; v_t1 = -30;
      wr_seg(0, 100, 5, 0, 1, 0, 0, 0);
      wr_seg(1, -100, 5, 0, 0, 0, 1, 0);
      rpt_cnt = 0;
      enable = 1;
      do_start();
      ticks(3);
      chk("R6", "upper clamp", off_s(), 250);
      ticks(5);
      chk("R6", "lower clamp", off_s(), -40);
      chk("R7", "cmp0 falling below", cmp0, 1);
      chk("R7", "cmp1 falling below", cmp1, 1);
      ticks(3);
      chk("R7", "cmp0 rising not above", cmp0, 0);
      chk("R7", "cmp1 rising above", cmp1, 1);
      chk("R6", "offset after rise", off_s(), 60);

      // R10 enable low stops and holds
      enable = 0; ticks(3);
      chk("R10", "offset held", off_s(), 60);
      chk("R10", "seg held", seg_idx, 0);
      enable = 1; ticks(3);
      chk("R10", "no resume without start", off_s(), 60);

      // random rounds
      for (int r = 0; r < 6; r++) begin
         enable = 0; step();
         for (int s = 0; s < 8; s++)
            wr_seg(s, longint'($urandom_range(0, 4000)) - 2000, $urandom_range(0, 6),
                   1'($urandom_range(0, 1)), $urandom_range(0, 7),
                   ($urandom_range(0, 1) == 1) ? 0 : $urandom_range(1, 3),
                   1'($urandom_range(0, 1)), $urandom_range(0, 3));
         v_hi = (r % 2 == 0) ? (longint'(1) << 32) - 1 : longint'($urandom_range(0, 20000));
         v_lo = (r % 2 == 0) ? -(longint'(1) << 32) : -longint'($urandom_range(0, 20000));
         v_t0 = longint'($urandom_range(0, 8000)) - 4000;
         v_t1 = longint'($urandom_range(0, 8000)) - 4000;
         rpt_cnt = 13'($urandom_range(0, 3));
         enable = 1;
         do_start();
         for (int c = 0; c < 3000; c++) begin
            tick   = ($urandom_range(0, 9) < 6);
            trig_a = ($urandom_range(0, 9) == 0) ? ~trig_a : trig_a;
            trig_b = ($urandom_range(0, 9) == 0) ? ~trig_b : trig_b;
            trig_c = ($urandom_range(0, 9) == 0) ? ~trig_c : trig_c;
            start  = ($urandom_range(0, 499) == 0);
            enable = ($urandom_range(0, 199) != 0);
            step();
         end
         tick = 0; start = 0; trig_a = 0; trig_b = 0; trig_c = 0; enable = 1;
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule